// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a one-cycle-wide 256 Hz enable strobe into a periodic interrupt whose rate is picked by a 3-bit code. The code sits in a byte-wide control register on a simple write/read bus. The same byte also holds a sticky event flag. Each completed period sets the flag. Software clears it by writing a zero into the flag's bit position. The interrupt output follows the flag.

Rates run from 256 Hz down to 1 Hz. Two of the eight codes produce no events at all. A change of rate code restarts the tick divider, so the first event at a new rate arrives after one whole new period. A write that keeps the same code leaves the divider running, which lets software clear the flag without disturbing the period.

Top module: `prd_irq_gen`

## Requirements
- R1: After reset the control byte reads 0x00 and `irq` is low.
- R2: Control byte layout: bit 7 is the event flag, bits 6:4 are the rate code, and bits 3:0 always read 0. Writes to bits 3:0 have no effect.
- R3: The number of `tick_256` strobes per period depends on the rate code: code 1 gives 1 (256 Hz), code 2 gives 4 (64 Hz), code 3 gives 16 (16 Hz), code 4 gives 64 (4 Hz), code 5 gives 128 (2 Hz) and code 6 gives 256 (1 Hz).
- R4: Codes 0 and 7 produce no events. The flag is never set by any number of strobes while either code is selected.
- R5: On the clock edge where `tick_256` is high and that strobe completes a period, the flag sets. It is visible on `rdata` bit 7 and `irq` from that edge on.
- R6: A write with bit 7 equal to 0 clears the flag. A write with bit 7 equal to 1 leaves the flag unchanged.
- R7: When a period completes in the same cycle as a clearing write, the flag ends up set.
- R8: A write whose rate code differs from the current one restarts the divider. A strobe in that same cycle is not counted, and the first event comes after a full period of the new code. A write with an unchanged code does not restart the divider.
- R9: `irq` is high exactly when the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_256 | input | 1 | One-cycle 256 Hz enable strobe |
| bus_wr | input | 1 | Write strobe for the control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control byte |
| irq | output | 1 | Periodic interrupt, follows the flag |

## Verification
The flag, and with it `irq` and `bus_rdata` bit 7, changes at the same clock edge that samples the completing strobe. A written code shows on `bus_rdata` right after the write edge, so every result is due one edge after its stimulus. The bench drives inputs and samples outputs on falling edges. A behavioural model updates at each rising edge and is compared with the outputs at the next falling edge. Directed checks are placed half a cycle after the edge that should have produced their result.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RATE_OFF  = 3'd0,
    RATE_256  = 3'd1,
    RATE_64   = 3'd2,
    RATE_16   = 3'd3,
    RATE_4    = 3'd4,
    RATE_2    = 3'd5,
    RATE_1    = 3'd6,
    RATE_RSV  = 3'd7
  } rate_code_e;

  // true when the code produces events
  function automatic logic code_live(input logic [SEL_W-1:0] code);
    return (code != RATE_OFF) && (code != RATE_RSV);
  endfunction

  // log2 of strobes per period
  function automatic logic [3:0] div_shift(input logic [SEL_W-1:0] code);
    logic [3:0] s;
    case (code)
      RATE_256: s = 4'd0;
      RATE_64:  s = 4'd2;
      RATE_16:  s = 4'd4;
      RATE_4:   s = 4'd6;
      RATE_2:   s = 4'd7;
      RATE_1:   s = 4'd8;
      default:  s = 4'd0;
    endcase
    return s;
  endfunction

  // strobes per period
  function automatic int unsigned div_ticks(input logic [SEL_W-1:0] code);
    return 32'd1 << div_shift(code);
  endfunction
endpackage

// File: rtl/prd_ctrl_reg.sv
module prd_ctrl_reg
  import prd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  code,
  output logic              code_change
);
  logic [SEL_W-1:0] new_code;

  assign new_code    = wdata[SEL_LSB +: SEL_W];
  assign code_change = wr && (new_code != code);

  always_ff @(posedge clk) begin
    if (!rst_n)  code <= '0;
    else if (wr) code <= new_code;
  end

  assert_code_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> code == $past(new_code));
  assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(code));
endmodule

// File: rtl/prd_divider.sv
module prd_divider
  import prd_pkg::*;
#(
  parameter int unsigned MAX_DIV = 256,
  localparam int unsigned CNT_W  = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [SEL_W-1:0] code,
  output logic             period_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             live;
  logic             at_term;

  assign live    = code_live(code);
  assign term    = CNT_W'(div_ticks(code) - 32'd1);
  assign at_term = (cnt == term);
  assign period_evt = live && tick && !restart && at_term;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (live && tick)   cnt <= at_term ? '0 : cnt + 1'b1;
  end

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  assert_idle_codes_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !period_evt);
  assert_event_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> tick);
  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/prd_flag.sv
module prd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(flag));
endmodule

// File: rtl/prd_irq_gen.sv
module prd_irq_gen
  import prd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_LSB  = 4,
  parameter int unsigned FLAG_BIT = 7,
  parameter int unsigned MAX_DIV  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_256,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [SEL_W-1:0] code;
  logic             code_change;
  logic             period_evt;
  logic             clr_req;
  logic             flag;

  assign clr_req = bus_wr && !bus_wdata[FLAG_BIT];

  prd_ctrl_reg #(.DATA_W(DATA_W), .SEL_LSB(SEL_LSB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .code(code), .code_change(code_change)
  );

  prd_divider #(.MAX_DIV(MAX_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_256), .restart(code_change),
    .code(code), .period_evt(period_evt)
  );

  prd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(period_evt), .clr_req(clr_req),
    .flag(flag)
  );

  always_comb begin
    bus_rdata = '0;
    bus_rdata[FLAG_BIT] = flag;
    bus_rdata[SEL_LSB +: SEL_W] = code;
  end

  assign irq = flag;

  assert_irq_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick_256));
  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[SEL_LSB-1:0] == '0);
endmodule

// File: tb/prd_irq_gen_tb.sv
module prd_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_256 = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  // reference model state
  int m_code = 0;
  int m_seen = 0;
  bit m_flag = 0;

  always #4 clk = ~clk;

  prd_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int strobes_for(int c);
    case (c)
      1: return 1;
      2: return 4;
      3: return 16;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_seen = 0; m_flag = 0;
    end else begin
      bit fire;
      int nc;
      fire = 0;
      nc = (bus_wdata >> 4) & 7;
      if (bus_wr && nc != m_code) m_seen = 0;
      else if (tick_256 && strobes_for(m_code) > 0) begin
        m_seen++;
        if (m_seen == strobes_for(m_code)) begin fire = 1; m_seen = 0; end
      end
      if (fire) m_flag = 1;
      else if (bus_wr && !bus_wdata[7]) m_flag = 0;
      if (bus_wr) m_code = nc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp;
      exp = {m_flag, 3'(m_code), 4'h0};
      vectors++;
      if (bus_rdata !== exp || irq !== m_flag) begin
        miscompares++;
        $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 phase, bus_rdata, irq, exp, m_flag);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] exp_rd, input bit exp_irq);
    vectors++;
    if (bus_rdata !== exp_rd || irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s directed: rdata=%h irq=%b expected rdata=%h irq=%b",
               req, bus_rdata, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d; tick_256 = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick_256 = 1'b0;
  endtask

  // n strobes, each followed by two idle cycles; ends at a negedge
  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_256 = 1'b1;
      @(negedge clk); tick_256 = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1"; check("R1", 8'h00, 0);

        phase = "R2"; wr_byte(8'h0F, 0); check("R2", 8'h00, 0);
        wr_byte(8'hAB, 0); check("R2", 8'h20, 0); // flag not set by writing 1
        wr_byte(8'h00, 0);

        phase = "R4"; wr_byte(8'h00, 0); strobes(300); check("R4", 8'h00, 0);
        wr_byte(8'h70, 0); strobes(300); check("R4", 8'h70, 0);

        phase = "R3"; wr_byte(8'h10, 0); strobes(1); check("R5", 8'h90, 1);
        check("R9", 8'h90, 1);
        wr_byte(8'h90, 0); check("R6", 8'h90, 1);
        wr_byte(8'h10, 0); check("R6", 8'h10, 0);

        wr_byte(8'h20, 0); strobes(3); check("R3", 8'h20, 0);
        strobes(1); check("R3", 8'hA0, 1);
        wr_byte(8'h20, 0); strobes(2);
        wr_byte(8'h20, 0); strobes(1); check("R8", 8'h20, 0);
        strobes(1); check("R8", 8'hA0, 1);

        wr_byte(8'h20, 0); strobes(3);
        phase = "R8"; wr_byte(8'h30, 1); strobes(15); check("R8", 8'h30, 0);
        strobes(1); check("R3", 8'hB0, 1);

        phase = "R3"; wr_byte(8'h40, 0); strobes(63); check("R3", 8'h40, 0);
        strobes(1); check("R3", 8'hC0, 1);
        wr_byte(8'h50, 0); strobes(127); check("R3", 8'h50, 0);
        strobes(1); check("R3", 8'hD0, 1);
        wr_byte(8'h60, 0); strobes(255); check("R3", 8'h60, 0);
        strobes(1); check("R3", 8'hE0, 1);

        phase = "R7"; wr_byte(8'h10, 0);
        wr_byte(8'h10, 1); check("R7", 8'h90, 1);
        wr_byte(8'h10, 0); check("R6", 8'h10, 0);
        idle(4);
      end
      begin
        idle(150000);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule